// File: doc/BRIEF.md
# Link Activation Sequencer

This block runs the start-up and shut-down handshake of a digital subscriber loop on its own, so a host only has to issue two commands: an activation request and a deactivation request. The sequencer steps the line through wake-up, training, sync acquisition and a pending phase using status flags from the receiver: far-end signal present, frame sync locked, and far-end activation bit. It drives the line transmitter enables and the outgoing activation and deactivation overhead bits itself.

Two start-up flavours are supported. A cold start trains for a full, parameterised period. A warm start skips training when the stored canceller and equaliser coefficients are flagged valid. Two optional breakpoints freeze the sequence until the host sends a continue pulse. Deactivation uses an announce period and a bounded quiet wait. An overall abort timer returns a stalled start-up to idle.

All timers are down-counters that step on a shared 1 ms tick. The tick comes from dividing the core clock, and every timer length is a parameter in milliseconds. Each state change, breakpoint halt and abort raises a one-cycle interrupt together with an event code.

Top module: `lnk_act_seq`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, the outputs are: `state_o`=0, `tx_en`=0, `tone_en`=0, `act_bit`=0, `dea_bit`=1, `halted`=0, `irq`=0 and `status`=0.
- R2: The `state_o` encoding is 0 idle, 1 wake, 2 train, 3 sync wait, 4 pending, 5 active, 6 announce, 7 quiet wait. The line outputs depend only on the state:
  - `tx_en` is 1 in states 1 to 6.
  - `tone_en` is 1 only in state 1.
  - `act_bit` is 1 only in states 4 and 5.
  - `dea_bit` is 0 only in states 6 and 7.
- R3: An `act_req` pulse in idle moves the block to wake on the next clock and starts the abort timer. In any other state, `act_req` has no effect.
- R4: A 1 ms tick occurs every `TICK_DIV` clocks, counted from reset. In wake with `sig_det`=1 and `coef_valid`=0, the block enters train and stays there until `T_TRAIN_MS` ticks have counted down. It then moves to sync wait.
- R5: In wake with `sig_det`=1 and `coef_valid`=1, the block goes straight to sync wait and never enters train.
- R6: Sync wait moves to pending when `sync_lock`=1. Pending moves to active when `far_act`=1, and entering active stops the abort timer.
- R7: With `bp_en[0]`=1, the exit from wake halts. With `bp_en[1]`=1, the exit from pending halts. While halted, `halted`=1 and the state is held until a `cont_req` pulse lets the exit proceed. A `cont_req` that arrives while the block is not halted has no effect.
- R8: `deact_req` in states 1 to 5 moves the block to announce (6) for `T_DEA_MS` ticks, then to quiet wait (7). In states 0, 6 and 7, `deact_req` has no effect.
- R9: Quiet wait returns to idle as soon as `sig_det`=0, or after `T_QUIET_MS` ticks, whichever comes first.
- R10: If the abort timer reaches `T_ABORT_MS` ticks in states 1 to 4, the block returns to idle with event code 3. Priority is `deact_req` first, then abort, then forward progress.
- R11: `irq` pulses for one clock in the same cycle that the event becomes visible. `status` then shows the event code: 1 for a state change, 2 for a breakpoint halt, 3 for an abort. Between events `status` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation command pulse |
| deact_req | input | 1 | Deactivation command pulse |
| cont_req | input | 1 | Continue pulse releasing a breakpoint |
| bp_en | input | 2 | Breakpoint enables (bit 0 wake exit, bit 1 pending exit) |
| coef_valid | input | 1 | Stored coefficients usable (warm start) |
| sig_det | input | 1 | Far-end signal present |
| sync_lock | input | 1 | Receiver frame sync locked |
| far_act | input | 1 | Received far-end activation bit |
| state_o | output | 3 | Current sequencer state |
| tx_en | output | 1 | Line transmitter enable |
| tone_en | output | 1 | Wake-up tone enable |
| act_bit | output | 1 | Outgoing activation overhead bit |
| dea_bit | output | 1 | Outgoing deactivation overhead bit (0 = deactivating) |
| halted | output | 1 | Sequence frozen at a breakpoint |
| irq | output | 1 | One-cycle event pulse |
| status | output | 2 | Code of the latest event |

## Verification
The hardest situation to reach is the abort timer expiring while the sequence is still activating. A breakpoint halt adds a further complication, because it interacts with the continue pulse and with the timers that count ticks on a divided clock. The bench shortens every timer through parameters: a 4-clock tick, a 40 ms abort and a few milliseconds per phase. This lets it walk cold, warm, halted, aborted and interrupted sequences in a few hundred clocks. A behavioural model steps alongside the block on every clock. It tracks the tick phase and the counter values, so any off-by-one in a timer or a priority shows up at once.

// File: rtl/lnk_act_pkg.sv
package lnk_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAKE    = 3'd1,
    ST_TRAIN   = 3'd2,
    ST_SYNC    = 3'd3,
    ST_PEND    = 3'd4,
    ST_ACTIVE  = 3'd5,
    ST_ANNOUNCE= 3'd6,
    ST_QUIET   = 3'd7
  } lnk_state_e;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_STATE   = 2'd1,
    EV_HALT    = 2'd2,
    EV_ABORT   = 2'd3
  } lnk_event_e;

  localparam int BP_WAKE = 0;
  localparam int BP_PEND = 1;
  localparam int BP_N    = 2;

  typedef struct packed {
    logic tx_en;
    logic tone_en;
    logic act_bit;
    logic dea_bit;
  } lnk_drive_t;

  function automatic lnk_drive_t drive_of(lnk_state_e s);
    lnk_drive_t d;
    d.tx_en   = (s != ST_IDLE) && (s != ST_QUIET);
    d.tone_en = (s == ST_WAKE);
    d.act_bit = (s == ST_PEND) || (s == ST_ACTIVE);
    d.dea_bit = (s != ST_ANNOUNCE) && (s != ST_QUIET);
    return d;
  endfunction

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lnk_ms_tick.sv
module lnk_ms_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/lnk_dn_timer.sv
module lnk_dn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic         stop,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (stop) begin
      run <= 1'b0;
    end else if (run && tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/lnk_act_fsm.sv
module lnk_act_fsm
  import lnk_act_pkg::*;
#(
  parameter int TW         = 14,
  parameter int T_TRAIN_MS = 5000,
  parameter int T_DEA_MS   = 40,
  parameter int T_QUIET_MS = 480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_req,
  input  logic            deact_req,
  input  logic            cont_req,
  input  logic [BP_N-1:0] bp_en,
  input  logic            coef_valid,
  input  logic            sig_det,
  input  logic            sync_lock,
  input  logic            far_act,
  input  logic            ph_done,
  input  logic            wd_done,
  output logic            ph_load,
  output logic            ph_stop,
  output logic [TW-1:0]   ph_val,
  output logic            wd_load,
  output logic            wd_stop,
  output lnk_state_e      state,
  output logic            halted,
  output logic            irq,
  output logic [1:0]      status
);
  lnk_state_e nxt;
  lnk_event_e ev;
  logic       halt_nxt;
  logic       go_wake, go_pend;

  assign go_wake = halted ? cont_req : (sig_det && !bp_en[BP_WAKE]);
  assign go_pend = halted ? cont_req : (far_act && !bp_en[BP_PEND]);

  always_comb begin
    nxt      = state;
    ev       = EV_NONE;
    halt_nxt = halted;
    ph_load  = 1'b0;
    ph_stop  = 1'b0;
    ph_val   = '0;
    wd_load  = 1'b0;
    wd_stop  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (act_req) begin
          nxt     = ST_WAKE;
          wd_load = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (deact_req) begin
          nxt     = ST_ANNOUNCE;
          ph_load = 1'b1;
          ph_val  = TW'(T_DEA_MS);
        end
      end
      ST_ANNOUNCE: begin
        if (ph_done) begin
          nxt     = ST_QUIET;
          ph_load = 1'b1;
          ph_val  = TW'(T_QUIET_MS);
        end
      end
      ST_QUIET: begin
        if (!sig_det || ph_done) begin
          nxt     = ST_IDLE;
          ph_stop = 1'b1;
        end
      end
      default: begin
        if (deact_req) begin
          nxt     = ST_ANNOUNCE;
          ph_load = 1'b1;
          ph_val  = TW'(T_DEA_MS);
          wd_stop = 1'b1;
        end else if (wd_done) begin
          nxt     = ST_IDLE;
          ev      = EV_ABORT;
          wd_stop = 1'b1;
          ph_stop = 1'b1;
        end else if (state == ST_WAKE) begin
          if (go_wake) begin
            if (coef_valid) begin
              nxt = ST_SYNC;
            end else begin
              nxt     = ST_TRAIN;
              ph_load = 1'b1;
              ph_val  = TW'(T_TRAIN_MS);
            end
          end else if (!halted && sig_det) begin
            halt_nxt = 1'b1;
            ev       = EV_HALT;
          end
        end else if (state == ST_TRAIN) begin
          if (ph_done) begin
            nxt     = ST_SYNC;
            ph_stop = 1'b1;
          end
        end else if (state == ST_SYNC) begin
          if (sync_lock) nxt = ST_PEND;
        end else begin
          if (go_pend) begin
            nxt     = ST_ACTIVE;
            wd_stop = 1'b1;
          end else if (!halted && far_act) begin
            halt_nxt = 1'b1;
            ev       = EV_HALT;
          end
        end
      end
    endcase
    if (nxt != state) begin
      halt_nxt = 1'b0;
      if (ev == EV_NONE) ev = EV_STATE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      halted <= 1'b0;
      irq    <= 1'b0;
      status <= 2'd0;
    end else begin
      state  <= nxt;
      halted <= halt_nxt;
      irq    <= (ev != EV_NONE);
      if (ev != EV_NONE) status <= ev;
    end
  end
endmodule

// File: rtl/lnk_act_seq.sv
module lnk_act_seq
  import lnk_act_pkg::*;
#(
  parameter int TICK_DIV   = 15360,
  parameter int T_TRAIN_MS = 5000,
  parameter int T_DEA_MS   = 40,
  parameter int T_QUIET_MS = 480,
  parameter int T_ABORT_MS = 15000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_req,
  input  logic       deact_req,
  input  logic       cont_req,
  input  logic [1:0] bp_en,
  input  logic       coef_valid,
  input  logic       sig_det,
  input  logic       sync_lock,
  input  logic       far_act,
  output logic [2:0] state_o,
  output logic       tx_en,
  output logic       tone_en,
  output logic       act_bit,
  output logic       dea_bit,
  output logic       halted,
  output logic       irq,
  output logic [1:0] status
);
  localparam int T_MAX = max_of4(T_TRAIN_MS, T_DEA_MS, T_QUIET_MS, T_ABORT_MS);
  localparam int TW    = $clog2(T_MAX + 1);

  logic          tick;
  logic          ph_load, ph_stop, ph_done;
  logic          wd_load, wd_stop, wd_done;
  logic [TW-1:0] ph_val;
  lnk_state_e    state;
  lnk_drive_t    drv;

  lnk_ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lnk_dn_timer #(.W(TW)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (ph_load),
    .stop     (ph_stop),
    .load_val (ph_val),
    .done     (ph_done)
  );

  lnk_dn_timer #(.W(TW)) u_abort_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wd_load),
    .stop     (wd_stop),
    .load_val (TW'(T_ABORT_MS)),
    .done     (wd_done)
  );

  lnk_act_fsm #(
    .TW         (TW),
    .T_TRAIN_MS (T_TRAIN_MS),
    .T_DEA_MS   (T_DEA_MS),
    .T_QUIET_MS (T_QUIET_MS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_req    (act_req),
    .deact_req  (deact_req),
    .cont_req   (cont_req),
    .bp_en      (bp_en),
    .coef_valid (coef_valid),
    .sig_det    (sig_det),
    .sync_lock  (sync_lock),
    .far_act    (far_act),
    .ph_done    (ph_done),
    .wd_done    (wd_done),
    .ph_load    (ph_load),
    .ph_stop    (ph_stop),
    .ph_val     (ph_val),
    .wd_load    (wd_load),
    .wd_stop    (wd_stop),
    .state      (state),
    .halted     (halted),
    .irq        (irq),
    .status     (status)
  );

  assign drv     = drive_of(state);
  assign state_o = state;
  assign tx_en   = drv.tx_en;
  assign tone_en = drv.tone_en;
  assign act_bit = drv.act_bit;
  assign dea_bit = drv.dea_bit;
endmodule

// File: rtl/lnk_act_chk.sv
module lnk_act_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act_req,
  input logic [2:0] state_o,
  input logic       dea_bit,
  input logic       halted,
  input logic       irq,
  input logic [1:0] status
);
  a_r11_change_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_o) |-> irq);

  a_r11_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(status));

  a_r11_irq_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 2'd0));

  a_r3_idle_goes_to_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd0 && state_o != 3'd0) |-> (state_o == 3'd1 && $past(act_req)));

  a_r8_dea_falls_in_announce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dea_bit) |-> (state_o == 3'd6));

  a_r6_active_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && $past(state_o) != 3'd5) |-> ($past(state_o) == 3'd4));

  a_r9_quiet_after_announce: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7 && $past(state_o) != 3'd7) |-> ($past(state_o) == 3'd6));

  a_r7_halt_only_at_bp: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (state_o == 3'd1 || state_o == 3'd4));

  a_r10_abort_lands_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status == 2'd3) |-> (state_o == 3'd0));
endmodule

bind lnk_act_seq lnk_act_chk u_chk (.*);

// File: tb/sim_lnk_act_seq.sv
module sim_lnk_act_seq;
  localparam int P_DIV   = 4;
  localparam int P_TRAIN = 5;
  localparam int P_DEA   = 3;
  localparam int P_QUIET = 6;
  localparam int P_ABORT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_req = 0, deact_req = 0, cont_req = 0;
  logic [1:0] bp_en = 2'b00;
  logic coef_valid = 0, sig_det = 0, sync_lock = 0, far_act = 0;
  logic [2:0] state_o;
  logic tx_en, tone_en, act_bit, dea_bit, halted, irq;
  logic [1:0] status;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lnk_act_seq #(
    .TICK_DIV(P_DIV), .T_TRAIN_MS(P_TRAIN), .T_DEA_MS(P_DEA),
    .T_QUIET_MS(P_QUIET), .T_ABORT_MS(P_ABORT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .deact_req(deact_req),
    .cont_req(cont_req), .bp_en(bp_en), .coef_valid(coef_valid),
    .sig_det(sig_det), .sync_lock(sync_lock), .far_act(far_act),
    .state_o(state_o), .tx_en(tx_en), .tone_en(tone_en), .act_bit(act_bit),
    .dea_bit(dea_bit), .halted(halted), .irq(irq), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st, m_tk, m_ph, m_wd, m_stat;
  bit m_phr, m_wdr, m_halt, m_irq;
  bit tk, phd, wdd, hn;
  int ns, ev, pa, pv, wa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tk = 0; m_ph = 0; m_wd = 0; m_stat = 0;
      m_phr = 0; m_wdr = 0; m_halt = 0; m_irq = 0;
    end else begin
      tk  = (m_tk == P_DIV - 1);
      phd = m_phr && (m_ph == 0);
      wdd = m_wdr && (m_wd == 0);
      ns = m_st; ev = 0; pa = 0; pv = 0; wa = 0; hn = m_halt;
      case (m_st)
        0: if (act_req) begin ns = 1; wa = 1; end
        5: if (deact_req) begin ns = 6; pa = 1; pv = P_DEA; end
        6: if (phd) begin ns = 7; pa = 1; pv = P_QUIET; end
        7: if (!sig_det || phd) begin ns = 0; pa = 2; end
        default: begin
          if (deact_req) begin ns = 6; pa = 1; pv = P_DEA; wa = 2; end
          else if (wdd) begin ns = 0; ev = 3; wa = 2; pa = 2; end
          else if (m_st == 1) begin
            if (m_halt ? cont_req : (sig_det && !bp_en[0])) begin
              if (coef_valid) ns = 3;
              else begin ns = 2; pa = 1; pv = P_TRAIN; end
            end else if (!m_halt && sig_det) begin hn = 1; ev = 2; end
          end else if (m_st == 2) begin
            if (phd) begin ns = 3; pa = 2; end
          end else if (m_st == 3) begin
            if (sync_lock) ns = 4;
          end else begin
            if (m_halt ? cont_req : (far_act && !bp_en[1])) begin ns = 5; wa = 2; end
            else if (!m_halt && far_act) begin hn = 1; ev = 2; end
          end
        end
      endcase
      if (pa == 1) begin m_ph = pv; m_phr = 1; end
      else if (pa == 2) m_phr = 0;
      else if (m_phr && tk && m_ph != 0) m_ph--;
      if (wa == 1) begin m_wd = P_ABORT; m_wdr = 1; end
      else if (wa == 2) m_wdr = 0;
      else if (m_wdr && tk && m_wd != 0) m_wd--;
      m_tk = tk ? 0 : m_tk + 1;
      if (ns != m_st) begin hn = 0; if (ev == 0) ev = 1; end
      m_halt = hn;
      m_irq  = (ev != 0);
      if (ev != 0) m_stat = ev;
      m_st = ns;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(state_o == 3'(m_st), "R3 R4 R5 R6 R8 R9 R10 state", state_o, m_st);
      chk(tx_en == (m_st >= 1 && m_st <= 6), "R2 tx_en", tx_en, (m_st >= 1 && m_st <= 6));
      chk(tone_en == (m_st == 1), "R2 tone_en", tone_en, (m_st == 1));
      chk(act_bit == (m_st == 4 || m_st == 5), "R2 act_bit", act_bit, (m_st == 4 || m_st == 5));
      chk(dea_bit == !(m_st == 6 || m_st == 7), "R2 dea_bit", dea_bit, !(m_st == 6 || m_st == 7));
      chk(halted == m_halt, "R7 halted", halted, m_halt);
      chk(irq == m_irq, "R11 irq", irq, m_irq);
      chk(status == 2'(m_stat), "R11 status", status, m_stat);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int target, input int limit);
    for (int i = 0; i < limit && state_o != 3'(target); i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        step(3);
        chk(state_o == 0 && !tx_en && dea_bit && !act_bit && !irq && status == 0 && !halted,
            "R1 reset state", state_o, 0);
        rst_n = 1'b1;
        step(5);

        // cold start
        act_req = 1; step(1); act_req = 0;
        chk(state_o == 1, "R3 wake after act_req", state_o, 1);
        step(3); sig_det = 1; step(1);
        chk(state_o == 2, "R4 cold start enters train", state_o, 2);
        wait_st(3, 100);
        chk(state_o == 3, "R4 train expires to sync wait", state_o, 3);
        step(2); sync_lock = 1; step(1);
        chk(state_o == 4, "R6 pending on sync lock", state_o, 4);
        step(2); far_act = 1; step(1);
        chk(state_o == 5, "R6 active on far act", state_o, 5);
        step(200);
        chk(state_o == 5, "R10 no abort once active", state_o, 5);
        act_req = 1; cont_req = 1; step(1); act_req = 0; cont_req = 0; step(1);
        chk(state_o == 5 && status == 1, "R3 act_req ignored when active", state_o, 5);

        // deactivation with quiet timer running out
        deact_req = 1; step(1); deact_req = 0;
        chk(state_o == 6 && !dea_bit, "R8 announce with dea low", state_o, 6);
        wait_st(7, 100);
        chk(state_o == 7 && !tx_en, "R9 quiet wait, transmitter off", state_o, 7);
        wait_st(0, 100);
        chk(state_o == 0, "R9 quiet timer back to idle", state_o, 0);
        far_act = 0; sync_lock = 0;
        deact_req = 1; step(1); deact_req = 0; step(1);
        chk(state_o == 0 && !irq, "R8 deact_req ignored in idle", state_o, 0);

        // warm start, then deactivate from sync wait with early quiet
        coef_valid = 1; step(3);
        act_req = 1; step(1); act_req = 0; step(1);
        chk(state_o == 3, "R5 warm start skips train", state_o, 3);
        step(2); deact_req = 1; step(1); deact_req = 0;
        chk(state_o == 6, "R8 deact from sync wait", state_o, 6);
        wait_st(7, 100); step(1); sig_det = 0; step(1);
        chk(state_o == 0, "R9 early exit on signal loss", state_o, 0);
        coef_valid = 0; step(4);

        // breakpoints
        bp_en = 2'b11;
        cont_req = 1; step(1); cont_req = 0;
        chk(state_o == 0 && !halted, "R7 cont_req ignored when not halted", state_o, 0);
        act_req = 1; step(1); act_req = 0; step(2); sig_det = 1; step(1);
        chk(halted && state_o == 1 && status == 2, "R7 halt at wake exit", state_o, 1);
        step(5);
        chk(halted && state_o == 1, "R7 held at breakpoint", state_o, 1);
        cont_req = 1; step(1); cont_req = 0;
        chk(state_o == 2 && !halted, "R7 continue into train", state_o, 2);
        wait_st(3, 100); sync_lock = 1; step(1); far_act = 1; step(2);
        chk(halted && state_o == 4, "R7 halt at pending exit", state_o, 4);
        cont_req = 1; step(1); cont_req = 0;
        chk(state_o == 5, "R7 continue into active", state_o, 5);
        deact_req = 1; step(1); deact_req = 0;
        sig_det = 0; far_act = 0; sync_lock = 0;
        wait_st(0, 100); bp_en = 2'b00; step(3);

        // deactivate during training
        act_req = 1; step(1); act_req = 0; sig_det = 1; step(2);
        chk(state_o == 2, "R4 train entered", state_o, 2);
        deact_req = 1; step(1); deact_req = 0;
        chk(state_o == 6, "R8 deact from train", state_o, 6);
        sig_det = 0; wait_st(0, 100); step(3);

        // abort timer
        act_req = 1; step(1); act_req = 0;
        wait_st(0, 400); step(1);
        chk(state_o == 0 && status == 3, "R10 abort returns to idle", state_o, 0);
        step(10);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule